// File: doc/BRIEF.md
# SPI Receive Word Buffer

This block is the receive-side holding stage of an SPI controller. It sits between the serial shifter and the host register interface. Each time the shifter finishes a transfer, it presents one parallel word for a single cycle. The block keeps that word either in a FIFO or, when the depth parameter is zero, in one holding register. The host takes words out with a read strobe on the receive-data address. The read word arrives, registered, one clock later.

The bus gives the receiver no way to hold off the sender. When a word completes while the store is full and nothing is read in that cycle, the new word is dropped and the stored words are kept. The block then raises a one-cycle overrun interrupt and sets a sticky overrun bit. A read of an empty store returns no valid word and sets a sticky read-error bit. The host clears both sticky bits through a write-one-to-clear strobe. A host write to the data address is acknowledged normally and changes nothing.

Stored contents are undefined after reset. Only words placed there by completed transfers are valid to read.

Top module: `spi_rx_buffer`

## Requirements
- R1: While reset is high and in the cycle after it is released, `sts_empty`=1, `sts_full`=0, `sts_overrun`=0, `sts_rd_err`=0, `irq_overrun`=0, `host_rd_ok`=0 and `host_wr_ack`=0.
- R2: Words are read out in the order their transfers completed. A read strobe on a non-empty store gives `host_rd_ok`=1 and the oldest word on `host_rd_word` in the following cycle.
- R3: With `DEPTH`=0 the store is one holding register. A completed transfer is kept only if the register is empty, or if the host reads the held word in that same cycle.
- R4: A completed transfer while the store is full and no read is strobed in that cycle is discarded, and the stored words stay unchanged. In the next cycle `irq_overrun` is high for one cycle per discarded word, and `sts_overrun` is set.
- R5: When a transfer completes and a read is strobed in the same cycle while the store is full, the read is served first and the new word is stored. No overrun is flagged and the store stays full.
- R6: A read strobe while the store is empty leaves `host_rd_ok` low in the next cycle and sets `sts_rd_err` in that cycle. The contents are unchanged.
- R7: A write strobe on the data address gives `host_wr_ack`=1 in the next cycle and changes neither the stored words nor the flags.
- R8: `sts_empty` is high exactly when no word is held. `sts_full` is high exactly when the count equals `DEPTH`, or 1 when `DEPTH`=0. Both follow a push or pop in the cycle after the edge that performs it.
- R9: A `stat_clr_stb` clears `sts_overrun` when `stat_clr_mask` bit 0 is 1, and clears `sts_rd_err` when bit 1 is 1. A new setting event in the same cycle wins over the clear.
- R10: `WORD_W` is 8, 16 or 32. `DEPTH` is 0, 16 or 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_done | input | 1 | One-cycle strobe: the shifter has completed a word |
| xfer_word | input | WORD_W | Word from the shifter, valid with `xfer_done` |
| host_rd_stb | input | 1 | Host read of the receive-data address |
| host_wr_stb | input | 1 | Host write of the receive-data address (ignored) |
| stat_clr_stb | input | 1 | Host write to the status clear port |
| stat_clr_mask | input | 2 | Clear mask: bit 0 overrun, bit 1 read error |
| host_rd_word | output | WORD_W | Word read, valid when `host_rd_ok` is high |
| host_rd_ok | output | 1 | Read completed with valid data |
| host_wr_ack | output | 1 | Success response for a data-address write |
| sts_empty | output | 1 | No word held |
| sts_full | output | 1 | Store at capacity |
| sts_overrun | output | 1 | Sticky: a word was dropped |
| sts_rd_err | output | 1 | Sticky: an empty store was read |
| irq_overrun | output | 1 | One-cycle pulse per dropped word |

## Verification
The bench builds two instances that share the same stimulus. One has `DEPTH`=16 and `WORD_W`=16, and the other has `DEPTH`=0 and `WORD_W`=8. With the deep instance, wrap of the binary pointers, filling to the count limit and draining through it are all reachable. With the zero-depth instance, the single-register rule for when a new word is accepted can be checked against the same traffic. In that traffic, overruns, empty reads and read-while-full pushes happen every few cycles.

// File: rtl/spi_rxbuf_pkg.sv
package spi_rxbuf_pkg;

    localparam int CLR_OVR_BIT = 0;
    localparam int CLR_ERR_BIT = 1;

    // Per-cycle events produced by the storage stage
    typedef struct packed {
        logic push_ok;   // incoming word stored
        logic pop_ok;    // oldest word delivered to host
        logic drop;      // incoming word discarded (overrun)
        logic empty_rd;  // host read while nothing held
    } rxb_evt_t;

    typedef struct packed {
        logic overrun;
        logic rd_err;
    } rxb_sticky_t;

    function automatic bit width_ok(int w);
        return (w == 8) || (w == 16) || (w == 32);
    endfunction

    function automatic bit depth_ok(int d);
        return (d == 0) || (d == 16) || (d == 256);
    endfunction

    // Number of words the store can hold
    function automatic int cap_of(int d);
        return (d == 0) ? 1 : d;
    endfunction

    function automatic int cnt_bits(int d);
        return $clog2(cap_of(d) + 1);
    endfunction

endpackage

// File: rtl/rxb_store.sv
module rxb_store
    import spi_rxbuf_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop,
    output logic [WORD_W-1:0] head_word,
    output logic              empty,
    output logic              full,
    output rxb_evt_t          evt
);

    localparam int CAP = cap_of(DEPTH);
    localparam int CW  = cnt_bits(DEPTH);

    // Read is resolved before the push: a pop frees a slot this cycle
    always_comb begin
        evt.pop_ok   = pop & ~empty;
        evt.empty_rd = pop & empty;
        evt.drop     = push & full & ~(pop & ~empty);
        evt.push_ok  = push & ~(full & ~(pop & ~empty));
    end

    generate
        if (DEPTH == 0) begin : g_single
            logic [WORD_W-1:0] hold_q;
            logic              hold_v;

            always_ff @(posedge clk) begin
                if (rst) begin
                    hold_v <= 1'b0;
                end else if (evt.push_ok) begin
                    hold_v <= 1'b1;
                end else if (evt.pop_ok) begin
                    hold_v <= 1'b0;
                end
            end

            always_ff @(posedge clk) begin
                if (evt.push_ok) begin
                    hold_q <= push_word;
                end
            end

            assign head_word = hold_q;
            assign empty     = ~hold_v;
            assign full      = hold_v;
        end else begin : g_fifo
            localparam int PW = $clog2(CAP);

            logic [WORD_W-1:0] mem [CAP];
            logic [PW-1:0]     wptr;
            logic [PW-1:0]     rptr;
            logic [CW-1:0]     count;

            always_ff @(posedge clk) begin
                if (evt.push_ok) begin
                    mem[wptr] <= push_word;
                end
            end

            // CAP is a power of two, so pointers wrap by overflow
            always_ff @(posedge clk) begin
                if (rst) begin
                    wptr  <= '0;
                    rptr  <= '0;
                    count <= '0;
                end else begin
                    if (evt.push_ok) begin
                        wptr <= wptr + PW'(1);
                    end
                    if (evt.pop_ok) begin
                        rptr <= rptr + PW'(1);
                    end
                    count <= count + CW'(evt.push_ok) - CW'(evt.pop_ok);
                end
            end

            assign head_word = mem[rptr];
            assign empty     = (count == '0);
            assign full      = (count == CW'(CAP));
        end
    endgenerate

endmodule

// File: rtl/rxb_status.sv
module rxb_status
    import spi_rxbuf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  rxb_evt_t    evt,
    input  logic        clr_stb,
    input  logic [1:0]  clr_mask,
    output rxb_sticky_t sticky,
    output logic        irq
);

    logic clr_ovr;
    logic clr_err;

    assign clr_ovr = clr_stb & clr_mask[CLR_OVR_BIT];
    assign clr_err = clr_stb & clr_mask[CLR_ERR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky <= '0;
            irq    <= 1'b0;
        end else begin
            irq            <= evt.drop;
            sticky.overrun <= evt.drop | (sticky.overrun & ~clr_ovr);
            sticky.rd_err  <= evt.empty_rd | (sticky.rd_err & ~clr_err);
        end
    end

endmodule

// File: rtl/rxb_host.sv
module rxb_host
    import spi_rxbuf_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  rxb_evt_t          evt,
    input  logic [WORD_W-1:0] head_word,
    input  logic              wr_stb,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_ok,
    output logic              wr_ack
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_word <= '0;
            rd_ok   <= 1'b0;
            wr_ack  <= 1'b0;
        end else begin
            rd_ok  <= evt.pop_ok;
            wr_ack <= wr_stb;
            if (evt.pop_ok) begin
                rd_word <= head_word;
            end
        end
    end

endmodule

// File: rtl/spi_rx_buffer.sv
module spi_rx_buffer
    import spi_rxbuf_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_done,
    input  logic [WORD_W-1:0] xfer_word,
    input  logic              host_rd_stb,
    input  logic              host_wr_stb,
    input  logic              stat_clr_stb,
    input  logic [1:0]        stat_clr_mask,
    output logic [WORD_W-1:0] host_rd_word,
    output logic              host_rd_ok,
    output logic              host_wr_ack,
    output logic              sts_empty,
    output logic              sts_full,
    output logic              sts_overrun,
    output logic              sts_rd_err,
    output logic              irq_overrun
);

    rxb_evt_t          evt;
    rxb_sticky_t       sticky;
    logic [WORD_W-1:0] head_word;

    rxb_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (xfer_done),
        .push_word (xfer_word),
        .pop       (host_rd_stb),
        .head_word (head_word),
        .empty     (sts_empty),
        .full      (sts_full),
        .evt       (evt)
    );

    rxb_status u_status (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .clr_stb  (stat_clr_stb),
        .clr_mask (stat_clr_mask),
        .sticky   (sticky),
        .irq      (irq_overrun)
    );

    rxb_host #(.WORD_W(WORD_W)) u_host (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .head_word (head_word),
        .wr_stb    (host_wr_stb),
        .rd_word   (host_rd_word),
        .rd_ok     (host_rd_ok),
        .wr_ack    (host_wr_ack)
    );

    assign sts_overrun = sticky.overrun;
    assign sts_rd_err  = sticky.rd_err;

endmodule

// File: rtl/rxb_checker.sv
module rxb_checker
    import spi_rxbuf_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int DEPTH  = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       xfer_done,
    input logic       host_rd_stb,
    input logic       host_wr_stb,
    input logic       stat_clr_stb,
    input logic [1:0] stat_clr_mask,
    input logic       host_rd_ok,
    input logic       host_wr_ack,
    input logic       sts_empty,
    input logic       sts_full,
    input logic       sts_overrun,
    input logic       sts_rd_err,
    input logic       irq_overrun
);

    logic drop_now;
    assign drop_now = xfer_done & sts_full & ~host_rd_stb;

    initial begin
        assert_param_legal_R10: assert (width_ok(WORD_W) && depth_ok(DEPTH))
            else $error("illegal WORD_W %0d or DEPTH %0d", WORD_W, DEPTH);
    end

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(sts_empty && sts_full));

    assert_drop_pulses_R4: assert property (@(posedge clk) disable iff (rst)
        drop_now |=> (irq_overrun && sts_overrun));

    assert_irq_cause_R4: assert property (@(posedge clk) disable iff (rst)
        irq_overrun |-> $past(drop_now));

    assert_read_first_R5: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && sts_full && host_rd_stb) |=> (!irq_overrun && sts_full));

    assert_empty_read_R6: assert property (@(posedge clk) disable iff (rst)
        (host_rd_stb && sts_empty) |=> (sts_rd_err && !host_rd_ok));

    assert_read_valid_R2: assert property (@(posedge clk) disable iff (rst)
        (host_rd_stb && !sts_empty) |=> host_rd_ok);

    assert_wr_ack_R7: assert property (@(posedge clk) disable iff (rst)
        host_wr_stb |=> host_wr_ack);

    assert_wr_no_effect_R7: assert property (@(posedge clk) disable iff (rst)
        (host_wr_stb && !xfer_done && !host_rd_stb)
            |=> ($stable(sts_empty) && $stable(sts_full)));

    assert_clear_ovr_R9: assert property (@(posedge clk) disable iff (rst)
        (stat_clr_stb && stat_clr_mask[0] && !drop_now) |=> !sts_overrun);

    assert_clear_err_R9: assert property (@(posedge clk) disable iff (rst)
        (stat_clr_stb && stat_clr_mask[1] && !(host_rd_stb && sts_empty))
            |=> !sts_rd_err);

    generate
        if (DEPTH == 0) begin : g_single_chk
            assert_single_fill_R3: assert property (@(posedge clk) disable iff (rst)
                (xfer_done && sts_empty) |=> sts_full);
        end
    endgenerate

endmodule

bind spi_rx_buffer rxb_checker #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_rxb_chk (
    .clk           (clk),
    .rst           (rst),
    .xfer_done     (xfer_done),
    .host_rd_stb   (host_rd_stb),
    .host_wr_stb   (host_wr_stb),
    .stat_clr_stb  (stat_clr_stb),
    .stat_clr_mask (stat_clr_mask),
    .host_rd_ok    (host_rd_ok),
    .host_wr_ack   (host_wr_ack),
    .sts_empty     (sts_empty),
    .sts_full      (sts_full),
    .sts_overrun   (sts_overrun),
    .sts_rd_err    (sts_rd_err),
    .irq_overrun   (irq_overrun)
);

// File: tb/tb_spi_rx_buffer.sv
`timescale 1ns/1ps
module tb_spi_rx_buffer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xfer_done = 1'b0;
    logic [15:0] xfer_word = '0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic        clr_stb = 1'b0;
    logic [1:0]  clr_mask = '0;

    always #2.5 clk = ~clk;

    // Instance A: FIFO of 16 words, 16 bits wide
    logic [15:0] a_rd_word;
    logic a_rd_ok, a_wr_ack, a_empty, a_full, a_ovr, a_err, a_irq;
    // Instance B: single holding register, 8 bits wide
    logic [7:0]  b_rd_word;
    logic b_rd_ok, b_wr_ack, b_empty, b_full, b_ovr, b_err, b_irq;

    spi_rx_buffer #(.WORD_W(16), .DEPTH(16)) dut (
        .clk(clk), .rst(rst), .xfer_done(xfer_done), .xfer_word(xfer_word),
        .host_rd_stb(rd_stb), .host_wr_stb(wr_stb),
        .stat_clr_stb(clr_stb), .stat_clr_mask(clr_mask),
        .host_rd_word(a_rd_word), .host_rd_ok(a_rd_ok), .host_wr_ack(a_wr_ack),
        .sts_empty(a_empty), .sts_full(a_full), .sts_overrun(a_ovr),
        .sts_rd_err(a_err), .irq_overrun(a_irq)
    );

    spi_rx_buffer #(.WORD_W(8), .DEPTH(0)) dut0 (
        .clk(clk), .rst(rst), .xfer_done(xfer_done), .xfer_word(xfer_word[7:0]),
        .host_rd_stb(rd_stb), .host_wr_stb(wr_stb),
        .stat_clr_stb(clr_stb), .stat_clr_mask(clr_mask),
        .host_rd_word(b_rd_word), .host_rd_ok(b_rd_ok), .host_wr_ack(b_wr_ack),
        .sts_empty(b_empty), .sts_full(b_full), .sts_overrun(b_ovr),
        .sts_rd_err(b_err), .irq_overrun(b_irq)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t",
                     req, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int unsigned qa[$];
    int unsigned qb[$];
    bit m_ovr[2], m_err[2], m_irq[2], m_rdok[2], m_ack[2];
    int unsigned m_rd[2];
    int m_cap[2] = '{16, 1};

    task automatic model_step(ref int unsigned q[$], input int k, input int unsigned din);
        bit was_empty;
        bit clr_o;
        bit clr_e;
        was_empty = (q.size() == 0);
        clr_o = clr_stb & clr_mask[0];
        clr_e = clr_stb & clr_mask[1];
        m_rdok[k] = rd_stb && !was_empty;
        if (m_rdok[k]) m_rd[k] = q.pop_front();
        m_ack[k] = wr_stb;
        m_irq[k] = 1'b0;
        if (xfer_done) begin
            if (q.size() < m_cap[k]) q.push_back(din);
            else m_irq[k] = 1'b1;
        end
        m_ovr[k] = m_irq[k] | (m_ovr[k] & ~clr_o);
        m_err[k] = (rd_stb & was_empty) | (m_err[k] & ~clr_e);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            qa.delete();
            qb.delete();
            for (int k = 0; k < 2; k++) begin
                m_ovr[k] = 0; m_err[k] = 0; m_irq[k] = 0; m_rdok[k] = 0; m_ack[k] = 0;
            end
        end else begin
            model_step(qa, 0, {16'h0, xfer_word});
            model_step(qb, 1, {24'h0, xfer_word[7:0]});
        end
        #1;
        if (!done) begin
            chk(a_empty == (qa.size() == 0), "R8", "A empty", a_empty, qa.size() == 0);
            chk(a_full == (qa.size() == 16), "R8", "A full", a_full, qa.size() == 16);
            chk(a_irq == m_irq[0], "R4", "A irq", a_irq, m_irq[0]);
            chk(a_ovr == m_ovr[0], "R4", "A overrun", a_ovr, m_ovr[0]);
            chk(a_err == m_err[0], "R6", "A rd_err", a_err, m_err[0]);
            chk(a_rd_ok == m_rdok[0], "R2", "A rd_ok", a_rd_ok, m_rdok[0]);
            chk(a_wr_ack == m_ack[0], "R7", "A wr_ack", a_wr_ack, m_ack[0]);
            if (m_rdok[0])
                chk(a_rd_word == m_rd[0][15:0], "R2", "A rd_word", a_rd_word, m_rd[0]);
            chk(b_empty == (qb.size() == 0), "R8", "B empty", b_empty, qb.size() == 0);
            chk(b_full == (qb.size() == 1), "R3", "B full", b_full, qb.size() == 1);
            chk(b_irq == m_irq[1], "R4", "B irq", b_irq, m_irq[1]);
            chk(b_ovr == m_ovr[1], "R4", "B overrun", b_ovr, m_ovr[1]);
            chk(b_err == m_err[1], "R6", "B rd_err", b_err, m_err[1]);
            chk(b_rd_ok == m_rdok[1], "R3", "B rd_ok", b_rd_ok, m_rdok[1]);
            chk(b_wr_ack == m_ack[1], "R7", "B wr_ack", b_wr_ack, m_ack[1]);
            if (m_rdok[1])
                chk(b_rd_word == m_rd[1][7:0], "R3", "B rd_word", b_rd_word, m_rd[1]);
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(input bit p, input logic [15:0] d, input bit r,
                       input bit w, input bit c, input logic [1:0] m);
        xfer_done = p; xfer_word = d; rd_stb = r; wr_stb = w;
        clr_stb = c; clr_mask = m;
        @(negedge clk);
        xfer_done = 0; rd_stb = 0; wr_stb = 0; clr_stb = 0; clr_mask = '0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        // R1: values while reset is held
        chk(a_empty && !a_full && !a_ovr && !a_err && !a_irq && !a_rd_ok && !a_wr_ack,
            "R1", "A reset flags", {a_empty, a_full, a_ovr, a_err, a_irq}, 5'b10000);
        chk(b_empty && !b_full && !b_ovr && !b_err && !b_irq && !b_rd_ok && !b_wr_ack,
            "R1", "B reset flags", {b_empty, b_full, b_ovr, b_err, b_irq}, 5'b10000);
        rst = 1'b0;
        @(negedge clk);
        chk(a_empty && !a_ovr && !a_err, "R1", "A after release",
            {a_empty, a_ovr, a_err}, 3'b100);
        // R10: configurations built with legal widths
        chk($bits(a_rd_word) == 16 && $bits(b_rd_word) == 8, "R10", "word widths",
            $bits(a_rd_word), 16);

        // Fill past capacity: drops on both instances
        for (int i = 0; i < 20; i++) cyc(1, 16'h0100 + 16'(i), 0, 0, 0, 2'b00);
        chk(a_full && a_ovr, "R4", "A full+overrun", {a_full, a_ovr}, 2'b11);
        chk(b_full && b_ovr, "R4", "B full+overrun", {b_full, b_ovr}, 2'b11);

        // R5: push with read while full
        cyc(1, 16'hABCD, 1, 0, 0, 2'b00);
        chk(!a_irq && a_full, "R5", "A read-first", {a_irq, a_full}, 2'b01);
        chk(!b_irq && b_full, "R5", "B read-first", {b_irq, b_full}, 2'b01);
        chk(b_rd_word == 8'h00, "R3", "B held first word", b_rd_word, 8'h00);

        // R9: clear overrun
        cyc(0, 16'h0, 0, 0, 1, 2'b01);
        chk(!a_ovr && !b_ovr, "R9", "overrun cleared", {a_ovr, b_ovr}, 2'b00);

        // Drain and over-read
        for (int i = 0; i < 20; i++) cyc(0, 16'h0, 1, 0, 0, 2'b00);
        chk(a_err && b_err && a_empty, "R6", "empty read error", {a_err, b_err}, 2'b11);
        cyc(0, 16'h0, 0, 0, 1, 2'b10);
        chk(!a_err && !b_err, "R9", "rd_err cleared", {a_err, b_err}, 2'b00);

        // R3: second word dropped when first not read
        cyc(1, 16'h005A, 0, 0, 0, 2'b00);
        cyc(1, 16'h00A5, 0, 0, 0, 2'b00);
        chk(b_irq == 1'b1, "R3", "B drop unread", b_irq, 1);
        cyc(0, 16'h0, 1, 0, 0, 2'b00);
        chk(b_rd_word == 8'h5A, "R3", "B kept oldest", b_rd_word, 8'h5A);

        // R7: writes
        cyc(0, 16'h0, 0, 1, 0, 2'b00);
        chk(a_wr_ack && b_wr_ack && !a_empty, "R7", "write acked", {a_wr_ack, b_wr_ack}, 2'b11);

        // Mixed traffic
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            r = $urandom;
            cyc((r % 100) < 40, 16'($urandom), ((r >> 8) % 100) < 35,
                ((r >> 16) % 100) < 10, ((r >> 24) % 100) < 5, 2'($urandom));
        end
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule